// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the status side of the internal controller of a parallel NOR flash. It follows an internal program or erase job from the moment the command decoder accepts it (the final write-enable rising edge, seen here as a one-cycle start pulse) until the operation engine reports completion. While a job runs it pulls an open-drain ready/busy line low. On reads it replaces data bits 6 and 2 with two toggle flip-flops, and it tells the read path whether to return array data or the status byte.

Bit 6 flips on every read strobe while the device is busy, at any address. It does not flip during an erase suspend. Bit 2 flips only on reads that hit a sector being erased, whether that erase is running or suspended. So software can tell which sectors an erase covers, and whether the erase is active. A program aimed at a protected sector, or an erase whose selected sectors are all protected, does not reach the engine. The block shows a short busy window timed by a cycle counter instead. Sectors are addressed by the top address bits. The guard windows are given in microseconds and converted with the clock frequency parameter.

Top module: `nor_status_gen`

## Requirements
- R1: After reset, and whenever reset is asserted, `rb_pull_low` is 0, `status` is 8'h00 and `array_sel` is 1.
- R2: A `start_pgm` accepted in the idle state for an address whose sector is unprotected makes `rb_pull_low` 1 from the next cycle until the cycle after `op_done`. After that the block is idle and `rb_pull_low` is 0.
- R3: A `start_erase` accepted in idle latches the selected sectors as `erase_mask & ~prot_mask`, so protected sectors are dropped. If that result is nonzero, `rb_pull_low` stays 1 until `op_done`, and the latched selection is cleared when the erase completes.
- R4: While busy, `status[6]` inverts exactly once for each read strobe at any address. A read strobe is the cycle in which `oe_n` and `ce_n` first become low together; a read with only one of them low is not a strobe. Every accepted operation start clears `status[6]` and `status[2]` to 0. All other status bits are always 0.
- R5: While not busy (idle or erase-suspended), `status[6]` holds its value.
- R6: `status[2]` inverts on a read strobe whose address sector (address bits [ADDR_W-1 -: log2 SECT_N]) is in the latched erase selection. This holds during an active erase, an erase suspend, and a program inside a suspend. On any other read it holds.
- R7: `suspend_req` during an erase enters erase suspend, with `rb_pull_low` 0. `resume_req` in suspend returns to the erase, with `rb_pull_low` 1.
- R8: `start_pgm` during erase suspend runs a program. During it `rb_pull_low` is 1 and bit 6 toggles. Its `op_done` returns to erase suspend, not idle, and the erase can then be resumed.
- R9: An erase whose selection is entirely protected holds `rb_pull_low` at 1 for exactly ERS_GUARD_US*CLK_MHZ cycles. A program to a protected sector holds it for PGM_GUARD_US*CLK_MHZ cycles. The block then returns to the state it left (idle or erase suspend).
- R10: Starts while busy, `start_erase` during suspend, `suspend_req` outside an active erase, `resume_req` outside suspend, and `op_done` while idle or suspended are all ignored.
- R11: `array_sel` is 0 while busy. In erase suspend it is 0 for reads of a selected sector and 1 otherwise. In idle it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_pgm | input | 1 | One-cycle program start from the command decoder |
| pgm_addr | input | ADDR_W | Program target address |
| start_erase | input | 1 | One-cycle erase start |
| erase_mask | input | SECT_N | Sectors selected for erase |
| prot_mask | input | SECT_N | Protected sectors |
| suspend_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| op_done | input | 1 | Completion pulse from the operation engine |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| rd_addr | input | ADDR_W | Read address |
| rb_pull_low | output | 1 | Enable of the open-drain pull-down on ready/busy |
| status | output | 8 | Status byte (toggle bits at 6 and 2) |
| array_sel | output | 1 | 1 selects array data for the read, 0 selects status |

## Verification
The bench targets several corner cases, each tied to a specific mistake.

- **Partly protected erase.** A read of a dropped sector must leave bit 2 unchanged. A design that latched the raw mask would flip it.
- **Program inside a suspend.** Its completion must fall back to suspend. A design that returned to idle would release ready/busy and report array data for the suspended sectors.
- **Guard windows.** These are measured cycle by cycle, so an off-by-one counter shows up as a wrong length.
- **Ignored inputs.** A start or suspend that arrives while busy is followed by reads and a completion. If the input were wrongly accepted, the busy line or bit 2 would expose the phantom operation.

// File: rtl/nor_stat_pkg.sv
package nor_stat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PGM   = 3'd1,
      ST_ERS   = 3'd2,
      ST_ESUSP = 3'd3,
      ST_SPGM  = 3'd4,
      ST_GUARD = 3'd5
   } op_state_e;

   localparam int STAT_W   = 8;
   localparam int BIT_ANY  = 6;
   localparam int BIT_SECT = 2;

   function automatic int sect_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/nor_stat_sector.sv
module nor_stat_sector
   import nor_stat_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SECT_N = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SECT_N-1:0] mask,
   output logic              hit
);
   localparam int SECT_W = sect_bits(SECT_N);

   generate
      if (SECT_N == 1) begin : g_single
         assign hit = mask[0];
      end else begin : g_multi
         logic [SECT_W-1:0] idx;
         assign idx = addr[ADDR_W-1 -: SECT_W];
         assign hit = mask[idx];
      end
   endgenerate

endmodule

// File: rtl/nor_stat_seq.sv
module nor_stat_seq
   import nor_stat_pkg::*;
#(
   parameter int SECT_N       = 8,
   parameter int GUARD_ERS_CY = 400,
   parameter int GUARD_PGM_CY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_pgm,
   input  logic              pgm_prot,
   input  logic              start_erase,
   input  logic [SECT_N-1:0] erase_mask,
   input  logic [SECT_N-1:0] prot_mask,
   input  logic              suspend_req,
   input  logic              resume_req,
   input  logic              op_done,
   output op_state_e         st,
   output logic              busy,
   output logic [SECT_N-1:0] sel_mask,
   output logic              op_start
);
   localparam int GUARD_MAX = (GUARD_ERS_CY > GUARD_PGM_CY) ? GUARD_ERS_CY : GUARD_PGM_CY;
   localparam int CNT_W     = $clog2(GUARD_MAX + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic              ret_susp_q;
   logic              acc_pgm, acc_ers;
   logic [SECT_N-1:0] ers_eff;

   assign ers_eff  = erase_mask & ~prot_mask;
   assign acc_pgm  = start_pgm && (st == ST_IDLE || st == ST_ESUSP);
   assign acc_ers  = start_erase && !start_pgm && (st == ST_IDLE);
   assign op_start = acc_pgm || acc_ers;
   assign busy     = (st == ST_PGM) || (st == ST_ERS) || (st == ST_SPGM) || (st == ST_GUARD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt_q      <= '0;
         ret_susp_q <= 1'b0;
         sel_mask   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (acc_pgm) begin
                  if (pgm_prot) begin
                     st         <= ST_GUARD;
                     cnt_q      <= CNT_W'(GUARD_PGM_CY - 1);
                     ret_susp_q <= 1'b0;
                  end else begin
                     st <= ST_PGM;
                  end
               end else if (acc_ers) begin
                  if (ers_eff == '0) begin
                     st         <= ST_GUARD;
                     cnt_q      <= CNT_W'(GUARD_ERS_CY - 1);
                     ret_susp_q <= 1'b0;
                  end else begin
                     st       <= ST_ERS;
                     sel_mask <= ers_eff;
                  end
               end
            end
            ST_PGM: begin
               if (op_done) st <= ST_IDLE;
            end
            ST_ERS: begin
               if (op_done) begin
                  st       <= ST_IDLE;
                  sel_mask <= '0;
               end else if (suspend_req) begin
                  st <= ST_ESUSP;
               end
            end
            ST_ESUSP: begin
               if (acc_pgm) begin
                  if (pgm_prot) begin
                     st         <= ST_GUARD;
                     cnt_q      <= CNT_W'(GUARD_PGM_CY - 1);
                     ret_susp_q <= 1'b1;
                  end else begin
                     st <= ST_SPGM;
                  end
               end else if (resume_req) begin
                  st <= ST_ERS;
               end
            end
            ST_SPGM: begin
               if (op_done) st <= ST_ESUSP;
            end
            ST_GUARD: begin
               if (cnt_q == '0) begin
                  st <= ret_susp_q ? ST_ESUSP : ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nor_stat_toggle.sv
module nor_stat_toggle #(
   parameter int RD_SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   input  logic ce_n,
   input  logic busy,
   input  logic sect_hit,
   input  logic clr,
   output logic rd_strobe,
   output logic tog_any,
   output logic tog_sect
);
   logic rd_act, rd_act_q;

   generate
      if (RD_SYNC == 0) begin : g_direct
         assign rd_act = ~oe_n & ~ce_n;
      end else begin : g_sync
         logic [RD_SYNC-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[RD_SYNC-2:0], ~oe_n & ~ce_n};
         end
         assign rd_act = sh_q[RD_SYNC-1];
      end
   endgenerate

   assign rd_strobe = rd_act & ~rd_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act_q <= 1'b0;
         tog_any  <= 1'b0;
         tog_sect <= 1'b0;
      end else begin
         rd_act_q <= rd_act;
         if (clr) begin
            tog_any  <= 1'b0;
            tog_sect <= 1'b0;
         end else if (rd_strobe) begin
            if (busy)     tog_any  <= ~tog_any;
            if (sect_hit) tog_sect <= ~tog_sect;
         end
      end
   end

endmodule

// File: rtl/nor_status_gen.sv
module nor_status_gen
   import nor_stat_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int SECT_N       = 8,
   parameter int CLK_MHZ      = 4,
   parameter int ERS_GUARD_US = 100,
   parameter int PGM_GUARD_US = 1,
   parameter int RD_SYNC      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_pgm,
   input  logic [ADDR_W-1:0] pgm_addr,
   input  logic              start_erase,
   input  logic [SECT_N-1:0] erase_mask,
   input  logic [SECT_N-1:0] prot_mask,
   input  logic              suspend_req,
   input  logic              resume_req,
   input  logic              op_done,
   input  logic              oe_n,
   input  logic              ce_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rb_pull_low,
   output logic [7:0]        status,
   output logic              array_sel
);
   localparam int SECT_W       = sect_bits(SECT_N);
   localparam int GUARD_ERS_CY = ERS_GUARD_US * CLK_MHZ;
   localparam int GUARD_PGM_CY = PGM_GUARD_US * CLK_MHZ;

   generate
      if ((1 << $clog2(SECT_N)) != SECT_N) begin : g_bad_sect
         $error("SECT_N must be a power of two");
      end
      if (SECT_N > 1 && SECT_W > ADDR_W) begin : g_bad_addr
         $error("ADDR_W too small for SECT_N");
      end
      if (GUARD_ERS_CY < 1 || GUARD_PGM_CY < 1) begin : g_bad_guard
         $error("guard windows must be at least one cycle");
      end
      if (RD_SYNC < 0 || RD_SYNC == 1 || RD_SYNC > 4) begin : g_bad_sync
         $error("RD_SYNC must be 0 or 2..4");
      end
   endgenerate

   op_state_e         st;
   logic              busy, op_start, pgm_prot, rd_hit, rd_strobe;
   logic              tog_any, tog_sect;
   logic [SECT_N-1:0] sel_mask;

   nor_stat_sector #(.ADDR_W(ADDR_W), .SECT_N(SECT_N)) u_pgm_sect (
      .addr (pgm_addr),
      .mask (prot_mask),
      .hit  (pgm_prot)
   );

   nor_stat_sector #(.ADDR_W(ADDR_W), .SECT_N(SECT_N)) u_rd_sect (
      .addr (rd_addr),
      .mask (sel_mask),
      .hit  (rd_hit)
   );

   nor_stat_seq #(
      .SECT_N       (SECT_N),
      .GUARD_ERS_CY (GUARD_ERS_CY),
      .GUARD_PGM_CY (GUARD_PGM_CY)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_pgm   (start_pgm),
      .pgm_prot    (pgm_prot),
      .start_erase (start_erase),
      .erase_mask  (erase_mask),
      .prot_mask   (prot_mask),
      .suspend_req (suspend_req),
      .resume_req  (resume_req),
      .op_done     (op_done),
      .st          (st),
      .busy        (busy),
      .sel_mask    (sel_mask),
      .op_start    (op_start)
   );

   nor_stat_toggle #(.RD_SYNC(RD_SYNC)) u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .oe_n      (oe_n),
      .ce_n      (ce_n),
      .busy      (busy),
      .sect_hit  (rd_hit),
      .clr       (op_start),
      .rd_strobe (rd_strobe),
      .tog_any   (tog_any),
      .tog_sect  (tog_sect)
   );

   always_comb begin
      status           = '0;
      status[BIT_ANY]  = tog_any;
      status[BIT_SECT] = tog_sect;
   end

   assign rb_pull_low = busy;
   assign array_sel   = !busy && !rd_hit;

endmodule

// File: rtl/nor_status_gen_chk.sv
module nor_status_gen_chk
   import nor_stat_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input op_state_e st,
   input logic      op_start,
   input logic      rd_strobe,
   input logic      rd_hit,
   input logic      rb_pull_low,
   input logic [7:0] status,
   input logic      array_sel
);

   p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_IDLE |-> !rb_pull_low);

   p_susp_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_ESUSP |-> !rb_pull_low);

   p_any_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && rb_pull_low && !op_start) |=> status[6] != $past(status[6]));

   p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> (status == 8'h00));

   p_any_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rb_pull_low && !op_start) |=> $stable(status[6]));

   p_sect_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rd_strobe && rd_hit) && !op_start) |=> $stable(status[2]));

   p_array_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rb_pull_low |-> !array_sel);

   p_spare_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status & 8'hBB) == 8'h00);

endmodule

bind nor_status_gen nor_status_gen_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .st          (st),
   .op_start    (op_start),
   .rd_strobe   (rd_strobe),
   .rd_hit      (rd_hit),
   .rb_pull_low (rb_pull_low),
   .status      (status),
   .array_sel   (array_sel)
);

// File: tb/sim_nor_status_gen.sv
module sim_nor_status_gen;
   localparam int CLK_P   = 10;
   localparam int CLK_MHZ = 4;
   localparam int ERS_CY  = 100 * CLK_MHZ;
   localparam int PGM_CY  = 1 * CLK_MHZ;

   // action codes: 0 nop, 1 program, 2 erase, 3 read, 4 suspend, 5 resume, 6 done
   // entry = {act[2:0], arg[7:0], rb, bit6, bit2, array_sel}
   localparam int NV = 24;
   localparam logic [14:0] VEC [NV] = '{
      {3'd1, 8'h10, 4'b1000},  // R2 program sector 0
      {3'd3, 8'h10, 4'b1100},  // R4
      {3'd3, 8'hE0, 4'b1000},  // R4 any address
      {3'd3, 8'h40, 4'b1100},  // R4
      {3'd6, 8'h00, 4'b0101},  // R2 done, R5
      {3'd3, 8'h40, 4'b0101},  // R5 idle read holds
      {3'd2, 8'h86, 4'b1000},  // R3 erase 1,2,7 (7 protected) clears toggles
      {3'd3, 8'h20, 4'b1110},  // R6 sector 1 hit
      {3'd3, 8'hE0, 4'b1010},  // R3 dropped sector 7 miss
      {3'd3, 8'h40, 4'b1100},  // R6 sector 2 hit
      {3'd4, 8'h00, 4'b0100},  // R7 suspend, R11 selected sector
      {3'd3, 8'h40, 4'b0110},  // R6 suspended hit, R5
      {3'd3, 8'h00, 4'b0111},  // R11 unselected in suspend
      {3'd1, 8'h00, 4'b1000},  // R8 program in suspend
      {3'd3, 8'h20, 4'b1110},  // R8 R6
      {3'd3, 8'h60, 4'b1010},  // R8 miss
      {3'd6, 8'h00, 4'b0011},  // R8 back to suspend
      {3'd2, 8'h01, 4'b0011},  // R10 erase in suspend ignored
      {3'd5, 8'h00, 4'b1010},  // R7 resume
      {3'd6, 8'h00, 4'b0011},  // R3 erase done
      {3'd3, 8'h20, 4'b0011},  // R3 selection cleared
      {3'd6, 8'h00, 4'b0011},  // R10 done in idle
      {3'd4, 8'h00, 4'b0011},  // R10 suspend in idle
      {3'd5, 8'h00, 4'b0011}   // R10 resume in idle
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_pgm = 1'b0, start_erase = 1'b0;
   logic [7:0] pgm_addr = '0, erase_mask = '0, prot_mask = 8'h80, rd_addr = '0;
   logic       suspend_req = 1'b0, resume_req = 1'b0, op_done = 1'b0;
   logic       oe_n = 1'b1, ce_n = 1'b1;
   logic       rb_pull_low, array_sel;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   nor_status_gen #(.CLK_MHZ(CLK_MHZ)) u0 (
      .clk(clk), .rst_n(rst_n), .start_pgm(start_pgm), .pgm_addr(pgm_addr),
      .start_erase(start_erase), .erase_mask(erase_mask), .prot_mask(prot_mask),
      .suspend_req(suspend_req), .resume_req(resume_req), .op_done(op_done),
      .oe_n(oe_n), .ce_n(ce_n), .rd_addr(rd_addr),
      .rb_pull_low(rb_pull_low), .status(status), .array_sel(array_sel)
   );

   function automatic logic [3:0] obs();
      return {rb_pull_low, status[6], status[2], array_sel};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] act, input logic [7:0] arg);
      @(negedge clk);
      case (act)
         3'd1: begin start_pgm = 1'b1; pgm_addr = arg; end
         3'd2: begin start_erase = 1'b1; erase_mask = arg; end
         3'd3: begin rd_addr = arg; oe_n = 1'b0; ce_n = 1'b0; end
         3'd4: suspend_req = 1'b1;
         3'd5: resume_req = 1'b1;
         3'd6: op_done = 1'b1;
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      start_pgm = 1'b0; start_erase = 1'b0; suspend_req = 1'b0;
      resume_req = 1'b0; op_done = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
      #1;
   endtask

   task automatic part_read(input logic [7:0] a);
      @(negedge clk);
      rd_addr = a; oe_n = 1'b0; ce_n = 1'b1;
      @(negedge clk);
      oe_n = 1'b1;
      #1;
   endtask

   task automatic guard_len(output int n);
      n = 0;
      while (rb_pull_low && n < 5000) begin
         n++;
         @(negedge clk);
      end
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset outputs", obs(), 4'b0001);
      check("R1 reset status", status, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][14:12], VEC[i][11:4]);
         check($sformatf("table step %0d", i), obs(), VEC[i][3:0]);
      end

      // R9 protected program from idle
      @(negedge clk); start_pgm = 1'b1; pgm_addr = 8'hE5;
      @(negedge clk); start_pgm = 1'b0;
      guard_len(n);
      check("R9 program guard length", n, PGM_CY);
      check("R4 guard start cleared toggles", status, 8'h00);

      // R9 all-protected erase
      apply(3'd3, 8'h00);
      @(negedge clk); start_erase = 1'b1; erase_mask = 8'h80;
      @(negedge clk); start_erase = 1'b0;
      guard_len(n);
      check("R9 erase guard length", n, ERS_CY);
      check("R9 back to idle", obs(), 4'b0001);

      // R9 protected program inside suspend returns to suspend
      apply(3'd2, 8'h02);
      apply(3'd4, 8'h00);
      @(negedge clk); start_pgm = 1'b1; pgm_addr = 8'hE0;
      @(negedge clk); start_pgm = 1'b0;
      guard_len(n);
      check("R9 suspended guard length", n, PGM_CY);
      apply(3'd3, 8'h20);
      check("R9 R11 still suspended", obs(), 4'b0010);
      apply(3'd5, 8'h00);
      check("R7 resume after guard", rb_pull_low, 1'b1);
      apply(3'd6, 8'h00);

      // R10 start and suspend ignored while programming
      apply(3'd1, 8'h00);
      apply(3'd2, 8'h02);
      apply(3'd4, 8'h00);
      check("R10 suspend ignored in program", rb_pull_low, 1'b1);
      apply(3'd3, 8'h20);
      check("R10 erase ignored while busy", obs(), 4'b1100);
      part_read(8'h00);
      check("R4 partial strobe no toggle", obs(), 4'b1100);
      apply(3'd6, 8'h00);
      check("R10 single done suffices", obs(), 4'b0101);

      // R1 reset mid operation
      apply(3'd1, 8'h00);
      apply(3'd3, 8'h00);
      @(negedge clk); rst_n = 1'b0; #1;
      check("R1 reset while busy", obs(), 4'b0001);
      check("R1 reset status busy", status, 8'h00);

      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule